// File: doc/BRIEF.md
# Virtual-Channel Link Flow Control (Credit and On/Off)

This block governs when flits may leave the sender end of one physical link that carries several virtual channels (VCs). It also models the far end of the link: a per-VC receive buffer whose slots are released by a consumer, and a return path that carries flow-control information back to the sender. Both directions have a fixed latency, set by parameters, so the round trip of the control loop is known when the block is built.

A parameter picks one of two schemes. In credit mode the sender holds one counter per VC, starting at the receive buffer depth. A flit that is accepted lowers its VC's counter. Each slot the consumer frees sends one credit back, and that credit raises the counter again. A VC is ready only while its counter is nonzero. In on/off mode there are no counters. The receiver raises a per-VC stop level once occupancy reaches a high mark, and that high mark leaves room for every flit that can still be on its way. The stop level drops again only when occupancy falls below a lower mark. The sender is ready on a VC whenever the stop level it sees for that VC is low.

Top module: `lfc_link`

## Requirements
- R1: After reset every credit counter equals the buffer depth, every VC is ready, every receive occupancy is zero and both error flags are low.
- R2: `tx_vc` is a binary VC index. A flit is accepted (`tx_accept`=1) only when `tx_valid` is high and that VC is ready. In credit mode each acceptance lowers that VC's counter by one, so a VC whose buffer is never drained accepts exactly the buffer depth before it stalls.
- R3: A consumer pop on a VC whose occupancy is nonzero frees one slot and returns one credit. A pop on an empty VC is ignored: it sends no credit, and the counters read the buffer depth again once the link is idle.
- R4: An acceptance and a returning credit on the same VC in the same cycle leave that VC's counter unchanged.
- R5: A counter never drops below zero or rises above the depth. Any attempt to do so sets the sticky `cnt_err` flag.
- R6: No flit ever arrives at a full receive buffer. Such an arrival would set the sticky `drop_err` flag.
- R7: The round trip is LINK_LAT + CREDIT_LAT + 2 cycles. When the depth is at least the round trip, a VC fed every cycle with an always-draining consumer accepts a flit every cycle.
- R8: When the depth is below the round trip, a single streaming VC accepts depth flits per round trip. Alternating between two VCs hides the latency again.
- R9: In on/off mode the stop level of a VC rises as soon as occupancy reaches depth minus round trip, and the sender sees it CREDIT_LAT cycles later. With no draining, the buffer settles at the high mark plus the flits that were in flight, and that total does not exceed the depth.
- R10: In on/off mode the stop level stays high while occupancy is at or above half the high mark (rounded down, minimum 1). It clears once occupancy falls below that lower mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Sender has a flit to offer |
| tx_vc | input | VCW | VC index of the offered flit |
| tx_ready | output | NUM_VC | Per-VC permission to send |
| tx_accept | output | 1 | Offered flit is taken this cycle |
| rx_pop | input | NUM_VC | Consumer frees one slot per flagged VC |
| rx_arr_valid | output | 1 | A flit reaches the receiver this cycle |
| rx_arr_vc | output | VCW | VC of the arriving flit |
| tx_credits | output | NUM_VC*CW | Per-VC credit counters, VC0 in the low bits |
| rx_occ | output | NUM_VC*CW | Per-VC receive occupancy, VC0 in the low bits |
| cnt_err | output | 1 | Sticky counter violation flag |
| drop_err | output | 1 | Sticky arrival-at-full flag |

## Verification
The bench builds three copies, all with two VCs and both latencies set to 2, which gives a round trip of 6. The first runs in credit mode with depth 6, so the buffer exactly covers the loop and must stream without a gap. The second runs in on/off mode with depth 12, which puts the high mark at 6 and the low mark at 3, so the stop, the in-flight margin and the hysteresis can be observed. The third runs in credit mode with depth 3, so the rate drops to depth per round trip and interleaving two VCs restores it.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    typedef enum logic {
        FC_CREDIT = 1'b0,
        FC_ONOFF  = 1'b1
    } fc_mode_e;

    // High mark for on/off mode: room left for everything in flight
    function automatic int unsigned high_mark(int unsigned depth, int unsigned loop_cyc);
        return (depth > loop_cyc) ? (depth - loop_cyc) : 1;
    endfunction

    function automatic int unsigned low_mark(int unsigned hi);
        return (hi / 2 > 0) ? (hi / 2) : 1;
    endfunction

endpackage

// File: rtl/lfc_delay.sv
module lfc_delay #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];

endmodule

// File: rtl/lfc_tx_ctrl.sv
module lfc_tx_ctrl
    import lfc_pkg::*;
#(
    parameter int unsigned NVC   = 2,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned CW    = 4,
    parameter int unsigned VCW   = 1,
    parameter fc_mode_e    MODE  = FC_CREDIT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tx_valid,
    input  logic [VCW-1:0]          tx_vc,
    input  logic [NVC-1:0]          ret_in,
    output logic [NVC-1:0]          tx_ready,
    output logic                    tx_accept,
    output logic [NVC-1:0][CW-1:0]  cnt_out,
    output logic                    cnt_err
);
    typedef struct packed {
        logic [NVC-1:0][CW-1:0] cnt;
        logic                   err;
    } tx_state_t;

    tx_state_t      st_d, st_q;
    logic [NVC-1:0] send_oh;

    // Ready per VC: counter nonzero, or stop level low
    for (genvar v = 0; v < NVC; v++) begin : g_vc
        if (MODE == FC_CREDIT) begin : g_cr
            assign tx_ready[v] = (st_q.cnt[v] != '0);
        end else begin : g_oo
            assign tx_ready[v] = !ret_in[v];
        end

        AST_SEND_NEEDS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
            (MODE == FC_CREDIT) && send_oh[v] |=> (st_q.cnt[v] == $past(st_q.cnt[v]) - CW'(1)) || $past(ret_in[v])); // R2
        AST_SAME_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (MODE == FC_CREDIT) && send_oh[v] && ret_in[v] |=> st_q.cnt[v] == $past(st_q.cnt[v])); // R4
        AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[v] <= CW'(DEPTH)); // R5
    end

    always_comb begin
        tx_accept = 1'b0;
        send_oh   = '0;
        for (int v = 0; v < NVC; v++) begin
            if (tx_valid && tx_vc == VCW'(v) && tx_ready[v]) begin
                tx_accept  = 1'b1;
                send_oh[v] = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (MODE == FC_CREDIT) begin
            for (int v = 0; v < NVC; v++) begin
                case ({send_oh[v], ret_in[v]})
                    2'b10: begin
                        if (st_q.cnt[v] == '0) st_d.err = 1'b1;
                        else                   st_d.cnt[v] = st_q.cnt[v] - CW'(1);
                    end
                    2'b01: begin
                        if (st_q.cnt[v] == CW'(DEPTH)) st_d.err = 1'b1;
                        else                           st_d.cnt[v] = st_q.cnt[v] + CW'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= {NVC{CW'(DEPTH)}};
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_CNT_ERR: assert property (@(posedge clk) disable iff (!rst_n) !st_q.err); // R5

    assign cnt_out = st_q.cnt;
    assign cnt_err = st_q.err;

endmodule

// File: rtl/lfc_rx_buf.sv
module lfc_rx_buf #(
    parameter int unsigned NVC    = 2,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned CW     = 4,
    parameter int unsigned VCW    = 1,
    parameter int unsigned HI_LVL = 4,
    parameter int unsigned LO_LVL = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arr_valid,
    input  logic [VCW-1:0]          arr_vc,
    input  logic [NVC-1:0]          pop,
    output logic [NVC-1:0]          credit,
    output logic [NVC-1:0]          stop,
    output logic [NVC-1:0][CW-1:0]  occ_out,
    output logic                    drop_err
);
    typedef struct packed {
        logic [NVC-1:0][CW-1:0] occ;
        logic [NVC-1:0]         stop;
        logic                   drop;
    } rx_state_t;

    rx_state_t      st_d, st_q;
    logic [NVC-1:0] arr_oh;

    always_comb begin
        st_d = st_q;
        for (int v = 0; v < NVC; v++) begin
            arr_oh[v] = arr_valid && (arr_vc == VCW'(v));
            credit[v] = pop[v] && (st_q.occ[v] != '0);
            if (arr_oh[v] && !credit[v]) begin
                if (st_q.occ[v] == CW'(DEPTH)) st_d.drop = 1'b1;
                else                           st_d.occ[v] = st_q.occ[v] + CW'(1);
            end else if (credit[v] && !arr_oh[v]) begin
                st_d.occ[v] = st_q.occ[v] - CW'(1);
            end
            if (st_d.occ[v] >= CW'(HI_LVL))      st_d.stop[v] = 1'b1;
            else if (st_d.occ[v] < CW'(LO_LVL))  st_d.stop[v] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar v = 0; v < NVC; v++) begin : g_chk
        AST_CREDIT_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            credit[v] && !arr_oh[v] |=> st_q.occ[v] == $past(st_q.occ[v]) - CW'(1)); // R3
        AST_OFF_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.occ[v] >= CW'(HI_LVL) |-> st_q.stop[v]); // R9
        AST_OFF_HYST: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.stop[v] && st_q.occ[v] > CW'(LO_LVL) |=> st_q.stop[v]); // R10
    end

    AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n) !st_q.drop); // R6

    assign stop     = st_q.stop;
    assign occ_out  = st_q.occ;
    assign drop_err = st_q.drop;

endmodule

// File: rtl/lfc_link.sv
module lfc_link
    import lfc_pkg::*;
#(
    parameter int unsigned NUM_VC     = 2,
    parameter int unsigned BUF_DEPTH  = 8,
    parameter int unsigned LINK_LAT   = 2,
    parameter int unsigned CREDIT_LAT = 2,
    parameter fc_mode_e    MODE       = FC_CREDIT,
    parameter int unsigned VCW        = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    parameter int unsigned CW         = $clog2(BUF_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_valid,
    input  logic [VCW-1:0]         tx_vc,
    output logic [NUM_VC-1:0]      tx_ready,
    output logic                   tx_accept,
    input  logic [NUM_VC-1:0]      rx_pop,
    output logic                   rx_arr_valid,
    output logic [VCW-1:0]         rx_arr_vc,
    output logic [NUM_VC*CW-1:0]   tx_credits,
    output logic [NUM_VC*CW-1:0]   rx_occ,
    output logic                   cnt_err,
    output logic                   drop_err
);
    localparam int unsigned LOOP_CYC = LINK_LAT + CREDIT_LAT + 2;
    localparam int unsigned HI_LVL   = high_mark(BUF_DEPTH, LOOP_CYC);
    localparam int unsigned LO_LVL   = low_mark(HI_LVL);

    logic [NUM_VC-1:0]         credit, stop, ret_src, ret_dly;
    logic [NUM_VC-1:0][CW-1:0] cnt_vec, occ_vec;

    lfc_tx_ctrl #(
        .NVC(NUM_VC), .DEPTH(BUF_DEPTH), .CW(CW), .VCW(VCW), .MODE(MODE)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_vc(tx_vc),
        .ret_in(ret_dly), .tx_ready(tx_ready), .tx_accept(tx_accept),
        .cnt_out(cnt_vec), .cnt_err(cnt_err)
    );

    lfc_delay #(.W(1 + VCW), .STAGES(LINK_LAT)) u_fwd (
        .clk(clk), .rst_n(rst_n),
        .din({tx_accept, tx_vc}),
        .dout({rx_arr_valid, rx_arr_vc})
    );

    lfc_rx_buf #(
        .NVC(NUM_VC), .DEPTH(BUF_DEPTH), .CW(CW), .VCW(VCW),
        .HI_LVL(HI_LVL), .LO_LVL(LO_LVL)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .arr_valid(rx_arr_valid), .arr_vc(rx_arr_vc),
        .pop(rx_pop), .credit(credit), .stop(stop), .occ_out(occ_vec),
        .drop_err(drop_err)
    );

    // One return wire per VC carries credits or the stop level
    if (MODE == FC_CREDIT) begin : g_ret_cr
        assign ret_src = credit;
    end else begin : g_ret_oo
        assign ret_src = stop;
    end

    lfc_delay #(.W(NUM_VC), .STAGES(CREDIT_LAT)) u_ret (
        .clk(clk), .rst_n(rst_n), .din(ret_src), .dout(ret_dly)
    );

    assign tx_credits = cnt_vec;
    assign rx_occ     = occ_vec;

endmodule

// File: tb/sim_lfc_link.sv
module sim_lfc_link;
    import lfc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic       tx_valid = 1'b0;
    logic [0:0] tx_vc = '0;
    logic [1:0] rx_pop = '0;

    logic [1:0] rdy0, rdy1, rdy2;
    logic       acc_0, acc_1, acc_2;
    logic       av0, av1, av2;
    logic [0:0] avc0, avc1, avc2;
    logic [5:0] cr0, occ0;
    logic [7:0] cr1, occ1;
    logic [3:0] cr2, occ2;
    logic       ce0, ce1, ce2, de0, de1, de2;

    int n_tests = 0, n_fail = 0;
    int a0, a1, a2;
    logic done = 1'b0;

    lfc_link #(.NUM_VC(2), .BUF_DEPTH(6), .LINK_LAT(2), .CREDIT_LAT(2), .MODE(FC_CREDIT)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_vc(tx_vc), .tx_ready(rdy0),
        .tx_accept(acc_0), .rx_pop(rx_pop), .rx_arr_valid(av0), .rx_arr_vc(avc0),
        .tx_credits(cr0), .rx_occ(occ0), .cnt_err(ce0), .drop_err(de0));

    lfc_link #(.NUM_VC(2), .BUF_DEPTH(12), .LINK_LAT(2), .CREDIT_LAT(2), .MODE(FC_ONOFF)) u1 (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_vc(tx_vc), .tx_ready(rdy1),
        .tx_accept(acc_1), .rx_pop(rx_pop), .rx_arr_valid(av1), .rx_arr_vc(avc1),
        .tx_credits(cr1), .rx_occ(occ1), .cnt_err(ce1), .drop_err(de1));

    lfc_link #(.NUM_VC(2), .BUF_DEPTH(3), .LINK_LAT(2), .CREDIT_LAT(2), .MODE(FC_CREDIT)) u2 (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_vc(tx_vc), .tx_ready(rdy2),
        .tx_accept(acc_2), .rx_pop(rx_pop), .rx_arr_valid(av2), .rx_arr_vc(avc2),
        .tx_credits(cr2), .rx_occ(occ2), .cnt_err(ce2), .drop_err(de2));

    // Columns: vc, alternate, pop, cycles, accepts u0, accepts u1, accepts u2
    localparam int NROW = 5;
    localparam int TAB [NROW][7] = '{
        '{0, 0, 1, 30, 30, 30, 15},   // R7 R8 single stream
        '{1, 0, 0, 20,  6, 10,  3},   // R2 R9 no draining
        '{0, 1, 1, 20, 20, 20, 20},   // R8 interleaved VCs
        '{0, 0, 0, 12,  6, 10,  3},   // R2 R9 other VC
        '{1, 0, 1, 24, 24, 24, 12}    // R7 R8 second VC
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_row(input int vc, input int alt, input int pop, input int len);
        a0 = 0; a1 = 0; a2 = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            tx_valid = 1'b1;
            tx_vc    = (alt != 0) ? 1'(i % 2) : 1'(vc);
            rx_pop   = (pop != 0) ? 2'b11 : 2'b00;
            #5;
            if (acc_0) a0++;
            if (acc_1) a1++;
            if (acc_2) a2++;
        end
    endtask

    task automatic idle(input int cyc, input logic [1:0] pops);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            tx_valid = 1'b0;
            rx_pop   = pops;
        end
        #5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R1 reset state
        check("R1 u0 credits vc0", int'(cr0[2:0]), 6);
        check("R1 u0 credits vc1", int'(cr0[5:3]), 6);
        check("R1 u2 credits vc1", int'(cr2[3:2]), 3);
        check("R1 ready u0", int'(rdy0), 3);
        check("R1 ready u1", int'(rdy1), 3);
        check("R1 occupancy", int'(occ0) + int'(occ1) + int'(occ2), 0);
        check("R1 error flags", int'(ce0) + int'(de0) + int'(ce1) + int'(de1), 0);

        for (int r = 0; r < NROW; r++) begin
            idle(30, 2'b11);
            // R3: pops on empty buffers returned no credit
            check("R3 u0 credits idle", int'(cr0), (6 << 3) | 6);
            check("R3 u2 credits idle", int'(cr2), (3 << 2) | 3);
            run_row(TAB[r][0], TAB[r][1], TAB[r][2], TAB[r][3]);
            check($sformatf("R7/R2 row %0d u0 accepts", r), a0, TAB[r][4]);
            check($sformatf("R9 row %0d u1 accepts", r), a1, TAB[r][5]);
            check($sformatf("R8 row %0d u2 accepts", r), a2, TAB[r][6]);
            if (r == 0) check("R4 u0 vc0 credit steady under send+return", int'(cr0[2:0]), 1);
            if (r == 1) check("R2 u0 vc1 exhausted not ready", int'(rdy0[1]), 0);
            check("R5 counter error", int'(ce0) + int'(ce2), 0);
            check("R6 drop", int'(de0) + int'(de1) + int'(de2), 0);
        end

        // R9 / R10 directed: stop level and hysteresis on u1 vc1
        idle(30, 2'b11);
        run_row(1, 0, 0, 12);
        idle(6, 2'b00);
        check("R9 u1 vc1 occupancy after stop", int'(occ1[7:4]), 10);
        check("R9 u1 vc1 stopped", int'(rdy1[1]), 0);
        idle(6, 2'b10);
        idle(5, 2'b00);
        check("R10 u1 vc1 occupancy at 4", int'(occ1[7:4]), 4);
        check("R10 u1 vc1 still stopped above low mark", int'(rdy1[1]), 0);
        idle(2, 2'b10);
        idle(5, 2'b00);
        check("R10 u1 vc1 occupancy at 2", int'(occ1[7:4]), 2);
        check("R10 u1 vc1 released below low mark", int'(rdy1[1]), 1);
        check("R6 final drop flags", int'(de0) + int'(de1) + int'(de2), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule